// File: doc/BRIEF.md
# Four-Phase Handshake Word Crossing

This block carries an occasional multi-bit word from one clock domain to another, unrelated one. It uses a request/acknowledge handshake rather than a FIFO. On the source side, a caller offers a word together with a one-cycle start strobe. The source registers the word, raises a request line and keeps the word unchanged while the handshake runs. While the block cannot take a new word, it reports busy.

The request passes through a flop synchronizer into the destination domain. When the synchronized request rises, the destination registers the held word onto its output and pulses valid for one destination clock. It then raises an acknowledge that follows the synchronized request. The acknowledge passes through a synchronizer of its own back to the source, which then drops the request. The destination drops the acknowledge, and the transfer ends when the source sees the acknowledge low again.

A complete transfer therefore spans about four synchronizer delays. The block suits configuration values and other rare transfers, not streaming data. Each domain has its own clock and its own active-low reset.

Top module: `hs_cdc_xfer`

## Requirements
- R1: After reset, busy_o is 0 and valid_o is 0 (the source request and the destination acknowledge are both cleared).
- R2: A start_i pulse while busy_o is 0 is accepted. The word on word_i is captured and busy_o reads 1 from the next source clock onward.
- R3: A start_i pulse while busy_o is 1 is ignored. Its word is never delivered, and the held source word does not change.
- R4: busy_o stays 1 until the acknowledge, seen through the source synchronizer, has returned low after the request fell. When busy_o falls, the accepted word has already been delivered.
- R5: Every accepted word is delivered exactly once on word_o, with its value intact and in acceptance order.
- R6: valid_o is high for exactly one destination clock per completed transfer. It never stays high for two consecutive destination clocks.
- R7: word_o changes only on the destination clock in which valid_o goes high, and holds its value between deliveries.
- R8: While the request is high, the source word register is unchanged.
- R9: The phases run in order: the request rises only while the synchronized acknowledge is low, and falls only while it is high. The acknowledge rises only while the synchronized request is high, and falls only while it is low.
- R10: Each control line crosses into the other domain through a chain of SYNC_STAGES (at least 2) plain flops with no logic between the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low |
| start_i | input | 1 | One-cycle strobe offering word_i |
| word_i | input | WIDTH | Word to be carried across |
| busy_o | output | 1 | High while a new word cannot be taken |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low |
| word_o | output | WIDTH | Last delivered word |
| valid_o | output | 1 | One-cycle pulse marking a new word_o |

## Verification
The bench issues a second start, with a different word, in the cycle right after an accepted one. A block that let that strobe through would either deliver an unexpected word or corrupt the word in flight, and the scoreboard would then see a wrong value or an extra item.

At each fall of busy, the bench compares the number of words delivered with the number accepted. A source that released busy at the acknowledge's rise, instead of waiting for its fall, would show a shortfall there, or later a lost word.

The destination clock runs both slower and much faster than the source clock. A valid stretched over two cycles, or a word_o that drifts between pulses, would be caught in the fast phase, where many destination cycles pass inside one transfer.

// File: rtl/hs_pkg.sv
package hs_pkg;
  // Accept a start strobe only when the source side is idle.
  function automatic logic take_start(input logic start, input logic busy);
    return start & ~busy;
  endfunction

  // Detect a low-to-high step between a previous and current sample.
  function automatic logic step_up(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // plain flop chain, nothing between the stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_src.sv
module hs_src #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] word,
  input  logic             ack_s,
  output logic             req,
  output logic [WIDTH-1:0] data,
  output logic             busy,
  output logic             accept
);
  import hs_pkg::*;

  assign busy   = req | ack_s;
  assign accept = take_start(start, busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= 1'b0;
      data <= '0;
    end else if (accept) begin
      req  <= 1'b1;
      data <= word;
    end else if (req && ack_s) begin
      req  <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_dst.sv
module hs_dst #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic [WIDTH-1:0] data,
  output logic             ack,
  output logic             rise,
  output logic [WIDTH-1:0] word,
  output logic             valid
);
  import hs_pkg::*;

  assign rise = step_up(req_s, ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      valid <= 1'b0;
      word  <= '0;
    end else begin
      ack   <= req_s;
      valid <= rise;
      if (rise) word <= data;
    end
  end
endmodule

// File: rtl/hs_cdc_xfer.sv
module hs_cdc_xfer #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             busy_o,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [WIDTH-1:0] word_o,
  output logic             valid_o
);
  // named internal events for the checker
  logic             src_req;
  logic             src_ack_s;
  logic [WIDTH-1:0] src_data;
  logic             src_accept;
  logic             dst_req_s;
  logic             dst_ack;
  logic             dst_rise;

  hs_src #(.WIDTH(WIDTH)) u_src (
    .clk(src_clk), .rst_n(src_rst_n), .start(start_i), .word(word_i),
    .ack_s(src_ack_s), .req(src_req), .data(src_data), .busy(busy_o),
    .accept(src_accept)
  );

  // R10: each control line gets its own flop chain
  hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(src_req), .q(dst_req_s)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(dst_ack), .q(src_ack_s)
  );

  hs_dst #(.WIDTH(WIDTH)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_n), .req_s(dst_req_s), .data(src_data),
    .ack(dst_ack), .rise(dst_rise), .word(word_o), .valid(valid_o)
  );
endmodule

// File: rtl/hs_cdc_chk.sv
module hs_cdc_chk #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic             src_clk,
  input logic             src_rst_n,
  input logic             dst_clk,
  input logic             dst_rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             src_req,
  input logic             src_ack_s,
  input logic [WIDTH-1:0] src_data,
  input logic             dst_req_s,
  input logic             dst_ack,
  input logic             valid_o,
  input logic [WIDTH-1:0] word_o
);
  // R10
  initial sync_depth_chk: assert (SYNC_STAGES >= 2);

  // R2
  start_taken_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (start_i && !busy_o) |=> (src_req && busy_o));

  // R3
  start_ignored_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (start_i && busy_o) |=> $stable(src_data));

  // R8
  data_hold_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_req && !start_i) |=> $stable(src_data));

  // R9
  req_rise_order_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(src_req) |-> !src_ack_s);

  // R9
  req_fall_order_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $fell(src_req) |-> src_ack_s);

  // R9
  ack_rise_order_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $rose(dst_ack) |-> dst_req_s);

  // R9
  ack_fall_order_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $fell(dst_ack) |-> !dst_req_s);

  // R6
  valid_single_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    valid_o |=> !valid_o);

  // R7
  word_hold_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !$stable(word_o) |-> valid_o);

  // R4
  busy_hold_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_req |-> busy_o);
endmodule

bind hs_cdc_xfer hs_cdc_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
  .start_i(start_i), .busy_o(busy_o), .src_req(src_req), .src_ack_s(src_ack_s),
  .src_data(src_data), .dst_req_s(dst_req_s), .dst_ack(dst_ack),
  .valid_o(valid_o), .word_o(word_o)
);

// File: tb/tb_hs_cdc_xfer.sv
module tb_hs_cdc_xfer;
  localparam int W = 16;

  logic         src_clk = 0, dst_clk = 0;
  logic         src_rst_n = 0, dst_rst_n = 0;
  logic         start_i = 0;
  logic [W-1:0] word_i = '0;
  logic         busy_o, valid_o;
  logic [W-1:0] word_o;

  int unsigned  dst_half = 23;
  int           checks = 0, fails = 0;
  int           sent = 0, got = 0;
  bit           done = 0;
  logic [W-1:0] expq[$];

  hs_cdc_xfer #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .start_i(start_i), .word_i(word_i),
    .busy_o(busy_o), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .word_o(word_o), .valid_o(valid_o)
  );

  always #10 src_clk = ~src_clk;            // 50 MHz
  always #(dst_half) dst_clk = ~dst_clk;    // unrelated, changed mid-run

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // driver: offer a word once idle, push it as expected
  task automatic send(input logic [W-1:0] w);
    @(negedge src_clk);
    while (busy_o) @(negedge src_clk);
    start_i = 1; word_i = w;
    expq.push_back(w);
    sent++;
    @(negedge src_clk);
    start_i = 0;
    chk(busy_o === 1'b1, "R2 busy after accepted start", busy_o, 1);
  endtask

  // wait for busy to drop and check delivery already happened
  task automatic drain();
    @(negedge src_clk);
    while (busy_o) @(negedge src_clk);
    chk(got == sent, "R4 delivered before busy falls", got, sent);
  endtask

  // monitor: pop and compare, check pulse width and hold
  logic         prev_valid = 0;
  logic [W-1:0] last_word = '0;
  initial begin
    forever begin
      @(negedge dst_clk);
      if (dst_rst_n) begin
        if (valid_o) begin
          chk(!prev_valid, "R6 valid single cycle", prev_valid, 0);
          if (expq.size() == 0) begin
            chk(0, "R5 unexpected delivery", word_o, 0);
          end else begin
            logic [W-1:0] e;
            e = expq.pop_front();
            chk(word_o === e, "R5 delivered word", word_o, e);
          end
          got++;
        end else begin
          if (word_o !== last_word) chk(0, "R7 word_o held between pulses", word_o, last_word);
        end
        last_word  = word_o;
        prev_valid = valid_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge src_clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge src_clk);
    src_rst_n = 1;
    dst_rst_n = 1;
    repeat (3) @(negedge src_clk);
    // R1 reset state
    chk(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
    chk(valid_o === 1'b0, "R1 valid after reset", valid_o, 0);
    chk(word_o === '0, "R1 word after reset", word_o, 0);

    // phase 1: destination slower than source
    send(16'hA5C3);
    drain();
    send(16'h0001);
    // R3: start in the next cycle while busy carries a word that must never appear
    chk(busy_o === 1'b1, "R3 still busy for second start", busy_o, 1);
    start_i = 1; word_i = 16'hDEAD;
    @(negedge src_clk);
    start_i = 0;
    drain();
    send(16'hFFFF);
    drain();

    // phase 2: destination much faster than source
    dst_half = 4;
    send(16'h1234);
    drain();
    send(16'h8000);
    // R3: a run of strobes while busy
    for (int i = 0; i < 5; i++) begin
      start_i = 1; word_i = 16'hBEEF;
      @(negedge src_clk);
    end
    start_i = 0;
    drain();
    send(16'h0000);
    drain();
    send(16'h5A5A);
    drain();

    repeat (20) @(negedge src_clk);
    chk(expq.size() == 0, "R5 all words delivered", expq.size(), 0);
    chk(got == sent, "R5 delivery count", got, sent);
    chk(busy_o === 1'b0, "R4 idle at end", busy_o, 0);
    chk(word_o === 16'h5A5A, "R7 last word held", word_o, 16'h5A5A);
    done = 1;
    summary();
  end
endmodule